// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block receives stereo audio from an external three-wire serial source made of a bit clock, a word-select line and a data line. The block is always a slave. It never drives the bit clock or the word-select line, and it samples data on the rising bit-clock edges after it has brought all three pins into the system clock domain. The source may use either I2S framing or LSB-justified framing. In LSB-justified framing the word length is set to 16, 18, 20 or 24 bits by a configuration input.

Every received word is aligned to a fixed 24-bit internal width, MSB at bit 23. Missing low bits are filled with zeros, and bits beyond the 24th are dropped. The number of bit clocks in a word-select period may change from frame to frame, up to 64, which covers 44.1 kHz and 48 kHz sources. When the right-channel word of a frame is complete, the block presents the left and right samples together with a one-cycle valid strobe in the system clock domain. The configuration inputs are expected to stay static while a stream runs. A controller changes them under reset.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and directly after it is released, valid_o is low and left_o and right_o are zero.
- R2: With fmt_i = 0 (I2S), data is sampled on rising sck_i edges. The bit sampled on the edge where ws_i first shows a new level is the last bit of the previous word. The next edge carries the MSB of the new word. A word received with ws_i low is the left sample, and a word received with ws_i high is the right sample.
- R3: In I2S mode a word shorter than 24 bits is zero-filled in its low bits, and any bits after the 24th bit of a word are discarded.
- R4: In I2S mode the value of wlen_i has no effect on the received samples.
- R5: With fmt_i = 1 (LSB-justified), the word is the N bits sampled on the N rising edges just before the edge that shows the word-select change, MSB first. N is set by wlen_i: 0 gives 16, 1 gives 18, 2 gives 20, 3 gives 24. The word occupies the top N output bits, the lower bits are zero, and earlier bits of the half-frame are ignored.
- R6: Any number of bit clocks per half-frame from the word length up to 32 (64 per frame) is received correctly. This number may differ from frame to frame.
- R7: Exactly one valid_o pulse, one cycle long, is produced for each left/right pair, after the right word completes. left_o and right_o change only in a cycle where valid_o is high.
- R8: The first word-select change after reset only aligns the receiver, so no partial word is emitted. A right word is emitted only if a left word has completed since the last pair.
- R9: sck_i, ws_i and sd_i each pass through two synchronising flops. Any bit clock whose high and low phases each last at least two clk_i periods is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock from the external master |
| ws_i | input | 1 | Word select from the external master |
| sd_i | input | 1 | Serial data |
| fmt_i | input | 1 | Framing: 0 = I2S, 1 = LSB-justified |
| wlen_i | input | 2 | LSB-justified word length: 0=16, 1=18, 2=20, 3=24 bits |
| left_o | output | 24 | Left sample, MSB aligned |
| right_o | output | 24 | Right sample, MSB aligned |
| valid_o | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
The bench targets I2S frames whose word fills the whole half-frame, so the LSB lands on the edge that shows the word-select change. A receiver that closes the word one edge early would shift every sample by a bit and lose the LSB. In LSB-justified mode the bench fills the slots ahead of the word with random data. A receiver that counts from the transition, instead of taking the last N bits, would return that junk. Each stream starts with a partial half-frame, which would produce a spurious pair if the receiver emitted a word before it had aligned. The bench also uses the fastest permitted bit clock, where a deeper or mismatched synchroniser would lose edges or pair the wrong word-select level with a bit.

// File: rtl/sai_pkg.sv
package sai_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LSBJ = 1'b1
  } fmt_e;

  // last N received bits, MSB-aligned into the sample width
  function automatic logic [SAMPLE_W-1:0] align_lsbj(input logic [SAMPLE_W-1:0] h,
                                                     input logic [1:0] wl);
    case (wl)
      2'd0:    return {h[15:0], 8'd0};
      2'd1:    return {h[17:0], 6'd0};
      2'd2:    return {h[19:0], 4'd0};
      default: return h;
    endcase
  endfunction
endpackage

// File: rtl/sai_sync.sv
module sai_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sai_bclk_edge.sv
module sai_bclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  output logic rise_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  assign rise_o = sck_s_i & ~sck_q;
endmodule

// File: rtl/sai_rx_deser.sv
module sai_rx_deser
  import sai_pkg::*;
#(
  parameter int MAX_BCLK = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_stb_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                fmt_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int CNT_W = $clog2(MAX_BCLK);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                have_prev_q, ws_prev_q, armed_q, left_seen_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] acc_q, hist_q, left_hold_q;
  logic [SAMPLE_W-1:0] acc_fill, word;
  logic                ws_chg;

  // I2S accumulator including the bit of the current edge
  always_comb begin
    acc_fill = acc_q;
    for (int i = 0; i < SAMPLE_W; i++)
      if (int'(cnt_q) == SAMPLE_W - 1 - i) acc_fill[i] = sd_i;
  end

  assign ws_chg = bit_stb_i & have_prev_q & (ws_i != ws_prev_q);
  assign word   = (fmt_i == FMT_I2S) ? acc_fill : align_lsbj(hist_q, wlen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      ws_prev_q   <= 1'b0;
      armed_q     <= 1'b0;
      left_seen_q <= 1'b0;
      cnt_q       <= '0;
      acc_q       <= '0;
      hist_q      <= '0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_stb_i) begin
        hist_q <= {hist_q[SAMPLE_W-2:0], sd_i};
        if (!have_prev_q) begin
          have_prev_q <= 1'b1;
          ws_prev_q   <= ws_i;
          cnt_q       <= '0;
          acc_q       <= '0;
        end else if (ws_chg) begin
          ws_prev_q <= ws_i;
          armed_q   <= 1'b1;
          cnt_q     <= '0;
          acc_q     <= '0;
          if (armed_q) begin
            if (!ws_prev_q) begin
              left_hold_q <= word;
              left_seen_q <= 1'b1;
            end else if (left_seen_q) begin
              left_o      <= left_hold_q;
              right_o     <= word;
              valid_o     <= 1'b1;
              left_seen_q <= 1'b0;
            end
          end
        end else begin
          acc_q <= acc_fill;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  valid_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_stb_i));

  // R7
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

  // R5
  lsbj_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_i) == FMT_LSBJ && $past(wlen_i) == 2'd0) |-> right_o[7:0] == 8'd0);

  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sai_pkg::*;
#(
  parameter int MAX_BCLK    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic        fmt_i,
  input  logic [1:0]  wlen_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic             bit_stb;

  sai_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, ws_i, sd_i}),
    .q_o    (pins_s)
  );

  sai_bclk_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_s_i (pins_s[2]),
    .rise_o  (bit_stb)
  );

  sai_rx_deser #(.MAX_BCLK(MAX_BCLK)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb),
    .ws_i      (pins_s[1]),
    .sd_i      (pins_s[0]),
    .fmt_i     (fmt_i),
    .wlen_i    (wlen_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni, sck, ws, sd, fmt;
  logic [1:0]  wlen;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  always #2 clk = ~clk;

  serial_audio_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .fmt_i(fmt), .wlen_i(wlen), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int checks = 0, fails = 0;
  logic [23:0] exp_l [0:63];
  logic [23:0] exp_r [0:63];
  int wr_ptr = 0, rd_ptr = 0;
  bit cur_fmt = 1'b0;
  int hp = 4;
  logic [31:0] last_word = '0;
  int last_lt = 0, last_b = 0;
  string tag = "R2";
  logic prev_valid = 1'b0;

  function automatic int nbits(input logic [1:0] wl);
    case (wl)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [31:0] mask_w(input logic [31:0] w, input int lt);
    if (lt >= 32) return w;
    return w & ((32'd1 << lt) - 32'd1);
  endfunction

  function automatic logic [23:0] expect_word(input logic [31:0] w, input int lt);
    if (lt >= 24) return 24'(w >> (lt - 24));
    return 24'(w << (24 - lt));
  endfunction

  task automatic slot(input bit wsv, input bit sdv);
    @(negedge clk);
    sck = 1'b0; ws = wsv; sd = sdv;
    repeat (hp) @(negedge clk);
    sck = 1'b1;
    repeat (hp - 1) @(negedge clk);
  endtask

  task automatic send_half(input bit wsv, input logic [31:0] word, input int lt, input int b);
    for (int p = 0; p < b; p++) begin
      bit bv;
      if (cur_fmt == 1'b0) begin
        if (p == 0) bv = (last_lt > 0 && last_lt == last_b) ? last_word[0] : 1'b0;
        else        bv = (p - 1 < lt) ? word[lt - p] : 1'b0;
      end else begin
        bv = (p >= b - lt) ? word[b - 1 - p] : 1'($urandom);
      end
      slot(wsv, bv);
    end
    last_word = word; last_lt = lt; last_b = b;
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int lt, input int b);
    logic [31:0] lm, rm;
    lm = mask_w(l, lt);
    rm = mask_w(r, lt);
    exp_l[wr_ptr] = expect_word(lm, lt);
    exp_r[wr_ptr] = expect_word(rm, lt);
    wr_ptr++;
    send_half(1'b0, lm, lt, b);
    send_half(1'b1, rm, lt, b);
  endtask

  // monitor: pair checks (R7 pulse width, R8 no spurious pair)
  always @(negedge clk) begin
    if (valid_o) begin
      checks++;
      if (prev_valid) begin
        fails++;
        $display("FAIL R7 valid_o high two cycles act=1 exp=0");
      end
      if (rd_ptr >= wr_ptr) begin
        checks++; fails++;
        $display("FAIL R8 unexpected pair act=%h/%h exp=none", left_o, right_o);
      end else begin
        checks += 2;
        if (left_o !== exp_l[rd_ptr]) begin
          fails++;
          $display("FAIL %s left act=%h exp=%h", tag, left_o, exp_l[rd_ptr]);
        end
        if (right_o !== exp_r[rd_ptr]) begin
          fails++;
          $display("FAIL %s right act=%h exp=%h", tag, right_o, exp_r[rd_ptr]);
        end
        rd_ptr++;
      end
    end
    prev_valid = valid_o;
  end

  task automatic run_seg(input bit f, input logic [1:0] wl, input int h, input int nrand, input string t);
    int n, lt, b;
    int opts [6] = '{16, 18, 20, 24, 28, 32};
    rst_ni = 1'b0; fmt = f; wlen = wl; hp = h;
    sck = 1'b0; ws = 1'b0; sd = 1'b0;
    wr_ptr = 0; rd_ptr = 0; cur_fmt = f; tag = t;
    last_word = '0; last_lt = 0; last_b = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || left_o !== 24'd0 || right_o !== 24'd0) begin
      fails++;
      $display("FAIL R1 reset state act=%b/%h/%h exp=0/0/0", valid_o, left_o, right_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    n = f ? nbits(wl) : 16;
    // partial lead-in half, must not produce a pair (R8)
    send_half(1'b1, 32'($urandom), n, n + 4);
    if (f == 1'b0) begin
      send_frame($urandom, $urandom, 32, 32);  // R3 drop, LSB on transition edge (R2)
      send_frame($urandom, $urandom, 16, 16);  // R3 zero fill, LSB on transition edge
      send_frame($urandom, $urandom, 24, 30);
    end else begin
      send_frame($urandom, $urandom, n, n);    // R5 no junk slots
      send_frame($urandom, $urandom, n, 32);   // R5 junk ahead of word, R6 max slots
    end
    for (int k = 0; k < nrand; k++) begin
      lt = f ? n : opts[$urandom % 6];
      b  = lt + int'($urandom % (33 - lt));   // R6 varying slots per half
      send_frame($urandom, $urandom, lt, b);
    end
    send_half(1'b0, 32'd0, 16, 16);
    repeat (20) @(negedge clk);
    checks++;
    if (rd_ptr != wr_ptr) begin
      fails++;
      $display("FAIL R8 pair count act=%0d exp=%0d", rd_ptr, wr_ptr);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0; fmt = 1'b0; wlen = 2'd0;
    run_seg(1'b0, 2'd2, 4, 8, "R2 R3 R4 R6");
    run_seg(1'b0, 2'd0, 2, 5, "R2 R3 R4 R9");
    run_seg(1'b1, 2'd0, 4, 6, "R5 R6");
    run_seg(1'b1, 2'd1, 4, 6, "R5 R6");
    run_seg(1'b1, 2'd2, 2, 6, "R5 R6 R9");
    run_seg(1'b1, 2'd3, 4, 6, "R5 R6");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule